// File: doc/BRIEF.md
# Single-Word Interrupt Aggregator

This block gathers a small, parameterised group of interrupt sources into one combined interrupt line. The enable and the pending status of every source share one 32-bit control word. Each source owns a lane. Its enable bit sits in the lower half of the word. Its status bit sits exactly 16 positions higher. The lanes start at a parameterised bit offset, `LANE_BASE`, and `NUM_SRC` lanes are present. The supported settings are offset 0 with 7 lanes, offset 0 with 6 lanes, and offset 4 with 2 lanes.

A rising edge on a source input latches that source's status bit, whatever its enable is. Software clears a status bit by writing 1 to it. Writing 0 to a status bit leaves it alone, so enables can be changed in the same word without losing pending events. The combined output is registered. It stays high while any lane has both its status and its enable set, which gives level-interrupt behaviour toward the parent controller.

Each lane holds a two-state machine. `LANE_IDLE` means nothing is latched. `LANE_PENDING` means an event is latched. The transition `latch` (IDLE to PENDING) is taken on a source rising edge. The transition `ack` (PENDING to IDLE) is taken on a write-one-to-clear without a coincident edge. The output stage holds a second two-state machine with the states `IRQ_QUIET` and `IRQ_RAISED`. The transition `raise` is taken when any enabled lane is pending. The transition `drop` is taken when no enabled lane is pending.

Top module: `irq_word_agg`

## Requirements
- R1: After reset the word reads 0x00000000 and `irq_o` is 0.
- R2: For lane i, the enable bit is at word bit LANE_BASE+i. It is an ordinary read/write bit, loaded from `reg_wdata_i` on every cycle where `reg_wr_i` is 1.
- R3: A 0-to-1 transition on `src_i[i]` sets the status bit at word bit 16+LANE_BASE+i whether or not the lane is enabled. The bit reads back 1 from the first clock edge that samples the source high. A source held high does not set the bit again after it is cleared.
- R4: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R5: When a rising source edge and a write-one-to-clear of the same status bit fall in the same cycle, the bit ends set.
- R6: `irq_o` is registered. One clock after any lane has both status and enable set, it is 1. One clock after no lane has both set, it is 0.
- R7: Word bits outside the configured enable and status lanes always read 0 and ignore writes.
- R8: `reg_rdata_o` shows the current enable and status values. Reading has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Source event inputs, one per lane |
| reg_wr_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 32 | Write data (enables low half, write-one-to-clear status high half) |
| reg_rdata_o | output | 32 | Current control word |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The hardest case to reach from the ports is a source edge that lands in the same cycle as a write clearing that lane's status bit. The stimulus table lines the two up by driving the source's rising step and the clearing write in one vector, and then checks that the bit survives. A second instance with a lane offset of 4 has unimplemented bits on both sides of its lanes. All-ones writes to it show that those bits stay 0.

// File: rtl/irq_word_agg_pkg.sv
package irq_word_agg_pkg;
    localparam int WORD_W   = 32;
    localparam int HALF_W   = 16;

    typedef enum logic {
        LANE_IDLE    = 1'b0,
        LANE_PENDING = 1'b1
    } lane_state_t;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_t;

    function automatic logic [HALF_W-1:0] lane_field(input int base, input int count);
        logic [HALF_W-1:0] m;
        m = '0;
        for (int k = 0; k < HALF_W; k++) begin
            if (k >= base && k < base + count) m[k] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/irq_lane.sv
module irq_lane
    import irq_word_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic wr_i,
    input  logic en_wbit_i,
    input  logic clr_wbit_i,
    output logic enable_o,
    output logic status_o
);
    lane_state_t state_q, state_d;
    logic        src_q;
    logic        rise;
    logic        ack;
    logic        enable_q;

    assign rise = src_i & ~src_q;
    assign ack  = wr_i & clr_wbit_i;

    // edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src_i;
    end

    // enable bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    enable_q <= 1'b0;
        else if (wr_i) enable_q <= en_wbit_i;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LANE_IDLE;
        else        state_q <= state_d;
    end

    // next state: latch / ack, set has priority
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LANE_IDLE:    if (rise) state_d = LANE_PENDING;
            LANE_PENDING: if (ack && !rise) state_d = LANE_IDLE;
            default:      state_d = LANE_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        enable_o = enable_q;
        status_o = (state_q == LANE_PENDING);
    end

    a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> status_o)
        else $error("a_r3_edge_sets");

    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_o && !rise) |=> !status_o)
        else $error("a_r3_no_spurious");

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && clr_wbit_i && !rise) |=> !status_o)
        else $error("a_r4_clear");

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !(wr_i && clr_wbit_i)) |=> status_o)
        else $error("a_r4_hold");

    a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && clr_wbit_i && src_i && !src_q) |=> status_o)
        else $error("a_r5_set_wins");

    a_r2_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (enable_o == $past(en_wbit_i)))
        else $error("a_r2_enable_load");
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
    import irq_word_agg_pkg::*;
#(
    parameter int NUM_SRC = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] status_i,
    input  logic [NUM_SRC-1:0] enable_i,
    output logic               irq_o
);
    irq_state_t state_q, state_d;
    logic       any_live;

    assign any_live = |(status_i & enable_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    // raise / drop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (any_live)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!any_live) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == IRQ_RAISED);
    end

    a_r6_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (|(status_i & enable_i)) |=> irq_o)
        else $error("a_r6_raise");

    a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(status_i & enable_i)) |=> !irq_o)
        else $error("a_r6_drop");
endmodule

// File: rtl/irq_word_agg.sv
module irq_word_agg
    import irq_word_agg_pkg::*;
#(
    parameter int NUM_SRC   = 7,
    parameter int LANE_BASE = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               reg_wr_i,
    input  logic [31:0]        reg_wdata_i,
    output logic [31:0]        reg_rdata_o,
    output logic               irq_o
);
    localparam int STAT_BASE = HALF_W + LANE_BASE;
    localparam logic [HALF_W-1:0] EN_FIELD = lane_field(LANE_BASE, NUM_SRC);
    localparam logic [WORD_W-1:0] LIVE_MASK = {EN_FIELD, EN_FIELD};

    logic [NUM_SRC-1:0] en_v;
    logic [NUM_SRC-1:0] st_v;

    initial begin
        if (LANE_BASE + NUM_SRC > HALF_W || NUM_SRC < 1)
            $error("lane configuration out of range");
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
        irq_lane u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_i      (src_i[i]),
            .wr_i       (reg_wr_i),
            .en_wbit_i  (reg_wdata_i[LANE_BASE + i]),
            .clr_wbit_i (reg_wdata_i[STAT_BASE + i]),
            .enable_o   (en_v[i]),
            .status_o   (st_v[i])
        );
    end

    irq_combiner #(.NUM_SRC(NUM_SRC)) u_comb (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (st_v),
        .enable_i (en_v),
        .irq_o    (irq_o)
    );

    // readback assembly
    always_comb begin
        reg_rdata_o = '0;
        for (int k = 0; k < NUM_SRC; k++) begin
            reg_rdata_o[LANE_BASE + k] = en_v[k];
            reg_rdata_o[STAT_BASE + k] = st_v[k];
        end
    end

    a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o & ~LIVE_MASK) == '0)
        else $error("a_r7_unused_zero");

    a_r8_stable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr_i && src_i == '0 && $past(src_i) == '0) |=> $stable(reg_rdata_o))
        else $error("a_r8_stable_idle");
endmodule

// File: tb/irq_word_agg_tb_top.sv
`timescale 1ns/1ps
module irq_word_agg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  src = '0;
    logic        wr = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic        irq;

    logic [1:0]  src_b = '0;
    logic        wr_b = 1'b0;
    logic [31:0] wd_b = '0;
    logic [31:0] rd_b;
    logic        irq_b;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    irq_word_agg #(.NUM_SRC(7), .LANE_BASE(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .reg_wr_i(wr),
        .reg_wdata_i(wd), .reg_rdata_o(rd), .irq_o(irq)
    );

    irq_word_agg #(.NUM_SRC(2), .LANE_BASE(4)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_b), .reg_wr_i(wr_b),
        .reg_wdata_i(wd_b), .reg_rdata_o(rd_b), .irq_o(irq_b)
    );

    // {src[6:0], wr, wdata, expected rdata, expected irq}
    localparam int NV = 15;
    localparam logic [72:0] VEC [NV] = '{
        {7'h00, 1'b1, 32'h0000_0005, 32'h0000_0005, 1'b0}, // R2 enable lanes 0,2
        {7'h01, 1'b0, 32'h0,         32'h0001_0005, 1'b0}, // R3 lane0 edge
        {7'h01, 1'b0, 32'h0,         32'h0001_0005, 1'b1}, // R6 raised
        {7'h02, 1'b0, 32'h0,         32'h0003_0005, 1'b1}, // R3 disabled lane1 latches
        {7'h02, 1'b1, 32'h0001_0005, 32'h0002_0005, 1'b1}, // R4 clear lane0 only
        {7'h00, 1'b0, 32'h0,         32'h0002_0005, 1'b0}, // R6 masked pending
        {7'h00, 1'b1, 32'h0000_0007, 32'h0002_0007, 1'b0}, // R4 zero keeps status
        {7'h00, 1'b0, 32'h0,         32'h0002_0007, 1'b1}, // R6 unmask raises
        {7'h00, 1'b1, 32'hFFFF_FF80, 32'h0000_0000, 1'b1}, // R7 R4 clear all
        {7'h00, 1'b0, 32'h0,         32'h0000_0000, 1'b0}, // R6 drop
        {7'h40, 1'b1, 32'h0000_0040, 32'h0040_0040, 1'b0}, // R3 lane6
        {7'h40, 1'b1, 32'h0040_0040, 32'h0000_0040, 1'b1}, // R3 held level no reset
        {7'h00, 1'b0, 32'h0,         32'h0000_0040, 1'b0}, // R6
        {7'h40, 1'b1, 32'h0040_0040, 32'h0040_0040, 1'b0}, // R5 set wins
        {7'h40, 1'b0, 32'h0,         32'h0040_0040, 1'b1}  // R5 R6
    };

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic chk1(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic [6:0] s, input logic we, input logic [31:0] w);
        src = s; wr = we; wd = w;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic step_b(input logic [1:0] s, input logic we, input logic [31:0] w);
        src_b = s; wr_b = we; wd_b = w;
        @(posedge clk);
        @(negedge clk);
        wr_b = 1'b0;
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk32("R1 rdata in reset", rd, 32'h0);
        chk1("R1 irq in reset", irq, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk32("R1 rdata after reset", rd, 32'h0);
        chk1("R1 irq after reset", irq, 1'b0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            step(VEC[v][72:66], VEC[v][65], VEC[v][64:33]);
            chk32($sformatf("R2/R3/R4 readback vec %0d", v), rd, VEC[v][32:1]);
            chk1($sformatf("R6 irq vec %0d", v), irq, VEC[v][0]);
        end

        // R8 reads are side-effect free: idle cycles keep the word
        step(7'h00, 1'b0, 32'h0);
        step(7'h00, 1'b0, 32'h0);
        chk32("R8 word stable over idle reads", rd, 32'h0040_0040);
        chk1("R8 irq stays", irq, 1'b1);

        // R7 offset instance: bits outside lanes 4,5 ignore writes
        step_b(2'b00, 1'b1, 32'hFFFF_FFFF);
        chk32("R7 offset enables only", rd_b, 32'h0000_0030);
        step_b(2'b11, 1'b0, 32'h0);
        chk32("R3 offset status lanes", rd_b, 32'h0030_0030);
        step_b(2'b11, 1'b0, 32'h0);
        chk1("R6 offset irq", irq_b, 1'b1);
        step_b(2'b11, 1'b1, 32'h0020_0000);
        chk32("R4 offset single clear", rd_b, 32'h0010_0000);
        step_b(2'b11, 1'b0, 32'h0);
        chk1("R6 offset drop after disable", irq_b, 1'b0);

        // R1 reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        chk32("R1 rdata mid reset", rd, 32'h0);
        chk1("R1 irq mid reset", irq, 1'b0);
        chk32("R1 offset rdata mid reset", rd_b, 32'h0);

        finish_up();
    end
endmodule